// File: doc/BRIEF.md
# Logic Analyzer Trigger Match Unit

This block decides, one probe sample at a time, whether a watched signal word meets a trigger condition that software loads at run time. Each probe bit carries its own condition. The condition can be a fixed level, a transition measured against the previous valid sample, a "free" setting (no per-bit constraint, but the bit still takes part in the word compare), or a masked setting (ignored completely). On top of the per-bit test, one word-level comparison is applied to the whole probe. The comparison can be an equality, an unsigned magnitude test against a reference, or an inclusive range test between two bounds.

The raw result is registered. It drives the match flag one cycle after the valid sample. An optional occurrence counter sits behind the raw result. It raises a second flag only on the Nth match. The build parameter `CNT_W` sets the counter width from 1 to 32 bits. A value of 0 is the default; it removes the counter, and the counted flag then simply follows the match flag. Settings are loaded through a small write port. The select code chooses the register, and any write restarts the edge history and the counter.

Top module: `trig_match_unit`

## Requirements
- R1: After reset both outputs are low, no previous sample is held, every bit code is 0 (free), the function is equal, both bounds are zero and the target is zero. So a valid sample of all zeros matches and any other value does not.
- R2: Per-bit codes are formed as {plane2,plane1,plane0} from the register planes at select 0, 1 and 2. The level codes are: 1 = bit must be 0, 2 = bit must be 1, 0 = free (any level, compared at word level), and 7 = masked (any level, excluded from word compare).
- R3: Transition codes compare against the previous valid sample: 3 = rise (0 to 1), 4 = fall (1 to 0), 5 = any change, 6 = no change. A cycle without sample_valid does not update the previous sample.
- R4: No transition code (3 to 6) is satisfied before the first valid sample that follows reset or a settings write.
- R5: The function code is written to cfg_data[2:0] at select 5. Code 0 = equal and code 1 = not equal, both compared against the low bound (select 3). Masked bits are forced to zero on both sides.
- R6: Codes 2, 3, 4 and 5 are probe > low, probe >= low, probe < low and probe <= low. All of them are unsigned.
- R7: Code 6 matches when low <= probe <= high (high at select 4, both bounds inclusive). Code 7 matches exactly when code 6 would not.
- R8: A match requires every per-bit condition and the word comparison to hold together.
- R9: match_o is high in the cycle after a valid sample that matched. It is low after any cycle without sample_valid.
- R10: With the counter present, the target is written to cfg_data[CNT_W-1:0] at select 6. count_hit_o pulses with match_o on the match that brings the running count to the target, and the count then restarts. Targets 0 and 1 give a pulse on every match. Non-matching samples are not counted.
- R11: Any settings write clears the previous-sample history and the counter, and both outputs are low in the next cycle. A sample presented in the same cycle as a write is discarded: it is neither matched nor stored.
- R12: With CNT_W = 0, count_hit_o equals match_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| probe_i | input | PROBE_W | Probe word to be judged |
| sample_valid_i | input | 1 | Probe word is a valid sample this cycle |
| cfg_wr_i | input | 1 | Write strobe for the settings |
| cfg_sel_i | input | 3 | Settings register select |
| cfg_data_i | input | PROBE_W | Settings write data |
| match_o | output | 1 | Registered raw match flag |
| count_hit_o | output | 1 | Registered counted match flag |

## Verification
The level conditions are tried with probe words that satisfy or break each constrained bit, while don't-care bits are toggled. This separates true per-bit matching from a plain word compare. The transition codes are driven through sequences that include an idle cycle and a fresh write. These separate history kept only on valid samples from history kept on every cycle, and show whether the first sample is rejected. Each comparison function is applied to values just below, at and above the bounds, plus a value with the top bit set. This exposes off-by-one bounds, inclusive versus exclusive range ends, and signed versus unsigned compares. The counter is checked with matching and non-matching samples mixed, with a write in the middle of a count, and with target zero, which shows where the count restarts.

// File: rtl/trig_match_pkg.sv
// Shared encodings of the trigger match unit: word function codes,
// per-bit condition codes and settings register select values.
package trig_match_pkg;

    typedef enum logic [2:0] {
        FN_EQ      = 3'd0,
        FN_NE      = 3'd1,
        FN_GT      = 3'd2,
        FN_GE      = 3'd3,
        FN_LT      = 3'd4,
        FN_LE      = 3'd5,
        FN_INSIDE  = 3'd6,
        FN_OUTSIDE = 3'd7
    } func_e;

    typedef enum logic [2:0] {
        CD_FREE   = 3'd0,
        CD_LOW    = 3'd1,
        CD_HIGH   = 3'd2,
        CD_RISE   = 3'd3,
        CD_FALL   = 3'd4,
        CD_TOGGLE = 3'd5,
        CD_STEADY = 3'd6,
        CD_MASKED = 3'd7
    } cond_e;

    localparam logic [2:0] SEL_PLANE0 = 3'd0;
    localparam logic [2:0] SEL_PLANE1 = 3'd1;
    localparam logic [2:0] SEL_PLANE2 = 3'd2;
    localparam logic [2:0] SEL_LOW    = 3'd3;
    localparam logic [2:0] SEL_HIGH   = 3'd4;
    localparam logic [2:0] SEL_FUNC   = 3'd5;
    localparam logic [2:0] SEL_TARGET = 3'd6;

endpackage

// File: rtl/trig_bit_cond.sv
// Per-bit condition evaluator.
// Each probe bit gets a 3-bit code built from three register planes.
// The module reports whether every bit meets its code, and which bits
// take part in the word-level compare (all except masked ones).
// Assumes prev_i is only meaningful while prev_ok_i is high.
module trig_bit_cond
    import trig_match_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] prev_i,
    input  logic             prev_ok_i,
    input  logic [WIDTH-1:0] plane0_i,
    input  logic [WIDTH-1:0] plane1_i,
    input  logic [WIDTH-1:0] plane2_i,
    output logic             all_ok_o,
    output logic [WIDTH-1:0] care_o
);

    logic [WIDTH-1:0] bit_ok;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        cond_e code;
        assign code = cond_e'({plane2_i[g], plane1_i[g], plane0_i[g]});

        // Judge one bit against its condition code.
        always_comb begin
            case (code)
                CD_LOW:    bit_ok[g] = !cur_i[g];
                CD_HIGH:   bit_ok[g] = cur_i[g];
                CD_RISE:   bit_ok[g] = prev_ok_i && !prev_i[g] && cur_i[g];
                CD_FALL:   bit_ok[g] = prev_ok_i && prev_i[g] && !cur_i[g];
                CD_TOGGLE: bit_ok[g] = prev_ok_i && (prev_i[g] != cur_i[g]);
                CD_STEADY: bit_ok[g] = prev_ok_i && (prev_i[g] == cur_i[g]);
                default:   bit_ok[g] = 1'b1;
            endcase
        end

        assign care_o[g] = (code != CD_MASKED);
    end

    assign all_ok_o = &bit_ok;

endmodule

// File: rtl/trig_word_cmp.sv
// Word-level comparator.
// Masked bits are forced to zero on both sides, then the probe is
// compared unsigned against the low bound, or against both bounds for
// the range functions (both ends inclusive).
// The clock and reset feed only the checking property.
module trig_word_cmp
    import trig_match_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] value_i,
    input  logic [WIDTH-1:0] low_i,
    input  logic [WIDTH-1:0] high_i,
    input  logic [WIDTH-1:0] care_i,
    input  func_e            func_i,
    output logic             ok_o
);

    logic [WIDTH-1:0] v_m, l_m, h_m;
    logic eq_w, gt_w, lt_w, in_w;

    assign v_m  = value_i & care_i;
    assign l_m  = low_i & care_i;
    assign h_m  = high_i & care_i;
    assign eq_w = (v_m == l_m);
    assign gt_w = (v_m > l_m);
    assign lt_w = (v_m < l_m);
    assign in_w = (v_m >= l_m) && (v_m <= h_m);

    // Select the programmed comparison result.
    always_comb begin
        case (func_i)
            FN_EQ:      ok_o = eq_w;
            FN_NE:      ok_o = !eq_w;
            FN_GT:      ok_o = gt_w;
            FN_GE:      ok_o = gt_w || eq_w;
            FN_LT:      ok_o = lt_w;
            FN_LE:      ok_o = lt_w || eq_w;
            FN_INSIDE:  ok_o = in_w;
            default:    ok_o = !in_w;
        endcase
    end

    // The three order outcomes are mutually exclusive (R6).
    p_order_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({eq_w, gt_w, lt_w}));

endmodule

// File: rtl/trig_event_cnt.sv
// Occurrence counter behind the raw match.
// fire_o is high for the event that brings the count to the target; the
// count then restarts. CNT_W = 0 removes the counter and passes events.
// Assumes clr_i is raised whenever target_i changes.
module trig_event_cnt #(
    parameter int CNT_W = 0,
    localparam int TGT_W = (CNT_W > 0) ? CNT_W : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             event_i,
    input  logic [TGT_W-1:0] target_i,
    output logic             fire_o
);

    if (CNT_W == 0) begin : g_none
        logic unused_cnt;
        assign unused_cnt = ^{clk, rst_n, clr_i, target_i};
        assign fire_o     = event_i;
    end else begin : g_cnt
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W:0]   cnt_inc;

        assign cnt_inc = {1'b0, cnt_q} + 1'b1;
        assign fire_o  = event_i && (cnt_inc >= {1'b0, target_i});

        // Count events, restart on a fire or a clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (clr_i) begin
                cnt_q <= '0;
            end else if (event_i) begin
                cnt_q <= fire_o ? '0 : cnt_inc[CNT_W-1:0];
            end
        end

        // The running count always stays below a target above one (R10).
        p_cnt_below_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (target_i > 1) |-> (cnt_q < target_i));
    end

endmodule

// File: rtl/trig_match_unit.sv
// Trigger match unit top.
// Holds the settings registers and the previous valid sample, combines the
// per-bit and word-level results, and registers match and counted flags.
// Assumes cfg_sel_i and cfg_data_i are stable while cfg_wr_i is high.
module trig_match_unit
    import trig_match_pkg::*;
#(
    parameter int PROBE_W = 16,
    parameter int CNT_W   = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PROBE_W-1:0] probe_i,
    input  logic               sample_valid_i,
    input  logic               cfg_wr_i,
    input  logic [2:0]         cfg_sel_i,
    input  logic [PROBE_W-1:0] cfg_data_i,
    output logic               match_o,
    output logic               count_hit_o
);

    localparam int TGT_W = (CNT_W > 0) ? CNT_W : 1;

    logic [PROBE_W-1:0] plane0_q, plane1_q, plane2_q;
    logic [PROBE_W-1:0] low_q, high_q, prev_q, care_w;
    logic [TGT_W-1:0]   target_q, target_d;
    func_e              func_q;
    logic               prev_ok_q, match_q, hit_q;
    logic               bits_ok, word_ok, event_w, fire_w;

    // Take the target from the low data bits, zero-extended.
    always_comb begin
        target_d = '0;
        for (int i = 0; i < TGT_W; i++) begin
            if (i < PROBE_W) target_d[i] = cfg_data_i[i];
        end
    end

    trig_bit_cond #(.WIDTH(PROBE_W)) u_bits (
        .cur_i     (probe_i),
        .prev_i    (prev_q),
        .prev_ok_i (prev_ok_q),
        .plane0_i  (plane0_q),
        .plane1_i  (plane1_q),
        .plane2_i  (plane2_q),
        .all_ok_o  (bits_ok),
        .care_o    (care_w)
    );

    trig_word_cmp #(.WIDTH(PROBE_W)) u_word (
        .clk     (clk),
        .rst_n   (rst_n),
        .value_i (probe_i),
        .low_i   (low_q),
        .high_i  (high_q),
        .care_i  (care_w),
        .func_i  (func_q),
        .ok_o    (word_ok)
    );

    assign event_w = sample_valid_i && !cfg_wr_i && bits_ok && word_ok;

    trig_event_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (cfg_wr_i),
        .event_i  (event_w),
        .target_i (target_q),
        .fire_o   (fire_w)
    );

    // Settings registers; a write also restarts the edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plane0_q <= '0;
            plane1_q <= '0;
            plane2_q <= '0;
            low_q    <= '0;
            high_q   <= '0;
            func_q   <= FN_EQ;
            target_q <= '0;
        end else if (cfg_wr_i) begin
            case (cfg_sel_i)
                SEL_PLANE0: plane0_q <= cfg_data_i;
                SEL_PLANE1: plane1_q <= cfg_data_i;
                SEL_PLANE2: plane2_q <= cfg_data_i;
                SEL_LOW:    low_q    <= cfg_data_i;
                SEL_HIGH:   high_q   <= cfg_data_i;
                SEL_FUNC:   func_q   <= func_e'(cfg_data_i[2:0]);
                SEL_TARGET: target_q <= target_d;
                default:    ;
            endcase
        end
    end

    // Previous valid sample, dropped on reset and on any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            prev_ok_q <= 1'b0;
        end else if (cfg_wr_i) begin
            prev_ok_q <= 1'b0;
        end else if (sample_valid_i) begin
            prev_q    <= probe_i;
            prev_ok_q <= 1'b1;
        end
    end

    // Output stage: registered raw and counted match flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            hit_q   <= 1'b0;
        end else begin
            match_q <= event_w;
            hit_q   <= fire_w;
        end
    end

    assign match_o     = match_q;
    assign count_hit_o = hit_q;

    // A counted flag never appears without the raw flag (R10).
    p_hit_needs_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count_hit_o |-> match_o);

    // A match only follows a valid sample (R9).
    p_match_after_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> $past(sample_valid_i));

    // A write silences both flags in the next cycle (R11).
    p_write_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_i |=> (!match_o && !count_hit_o));

endmodule

// File: tb/trig_match_unit_bench.sv
module trig_match_unit_bench;
    localparam int CLK_P = 10;
    localparam int PW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] probe = '0;
    logic          valid = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [PW-1:0] cfg_data = '0;
    logic          match, hit, match2, hit2;

    int n_chk = 0;
    int n_err = 0;

    // bench-side settings
    logic [2:0]    bc [PW];
    logic [PW-1:0] b_lo, b_hi, b_prev;
    logic [2:0]    b_func;
    logic          b_prev_ok;
    int            b_tgt, b_cnt;

    always #(CLK_P/2) clk = ~clk;

    trig_match_unit #(.PROBE_W(PW), .CNT_W(4)) u_trig_match_unit (
        .clk(clk), .rst_n(rst_n), .probe_i(probe), .sample_valid_i(valid),
        .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
        .match_o(match), .count_hit_o(hit));

    trig_match_unit #(.PROBE_W(PW)) u_trig_match_unit_nocnt (
        .clk(clk), .rst_n(rst_n), .probe_i(probe), .sample_valid_i(valid),
        .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
        .match_o(match2), .count_hit_o(hit2));

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic model_match(input logic [PW-1:0] p);
        logic ok;
        logic [PW-1:0] m, v, l, h;
        ok = 1'b1;
        for (int i = 0; i < PW; i++) begin
            m[i] = (bc[i] != 3'd7);
            case (bc[i])
                3'd1: ok &= !p[i];
                3'd2: ok &= p[i];
                3'd3: ok &= b_prev_ok && !b_prev[i] && p[i];
                3'd4: ok &= b_prev_ok && b_prev[i] && !p[i];
                3'd5: ok &= b_prev_ok && (b_prev[i] != p[i]);
                3'd6: ok &= b_prev_ok && (b_prev[i] == p[i]);
                default: ;
            endcase
        end
        v = p & m; l = b_lo & m; h = b_hi & m;
        case (b_func)
            3'd0: ok &= (v == l);
            3'd1: ok &= (v != l);
            3'd2: ok &= (v > l);
            3'd3: ok &= (v >= l);
            3'd4: ok &= (v < l);
            3'd5: ok &= (v <= l);
            3'd6: ok &= (v >= l) && (v <= h);
            default: ok &= !((v >= l) && (v <= h));
        endcase
        return ok;
    endfunction

    // one valid sample; check both flags one cycle later
    task automatic smp(input logic [PW-1:0] p, input string req);
        logic em, eh;
        em = model_match(p);
        eh = 1'b0;
        if (em) begin
            if (b_cnt + 1 >= b_tgt) begin eh = 1'b1; b_cnt = 0; end
            else b_cnt++;
        end
        probe = p; valid = 1'b1;
        @(posedge clk); @(negedge clk);
        valid = 1'b0;
        b_prev = p; b_prev_ok = 1'b1;
        check(req, "match", {31'd0, match}, {31'd0, em});
        check(req, "count_hit", {31'd0, hit}, {31'd0, eh});
    endtask

    // cycle without sample_valid: no match and no history update
    task automatic idle(input logic [PW-1:0] p);
        probe = p; valid = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R9", "match on idle", {31'd0, match}, 32'd0);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [PW-1:0] d, input logic with_smp, input logic [PW-1:0] p);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_data = d;
        valid = with_smp; probe = p;
        @(posedge clk); @(negedge clk);
        cfg_wr = 1'b0; valid = 1'b0;
        case (sel)
            3'd3: b_lo = d;
            3'd4: b_hi = d;
            3'd5: b_func = d[2:0];
            3'd6: b_tgt = int'(d[3:0]);
            default: ;
        endcase
        b_prev_ok = 1'b0; b_cnt = 0;
        check("R11", "match after write", {31'd0, match}, 32'd0);
        check("R11", "hit after write", {31'd0, hit}, 32'd0);
    endtask

    task automatic load_codes();
        logic [PW-1:0] p0, p1, p2;
        for (int i = 0; i < PW; i++) begin
            p0[i] = bc[i][0]; p1[i] = bc[i][1]; p2[i] = bc[i][2];
        end
        wr(3'd0, p0, 1'b0, '0);
        wr(3'd1, p1, 1'b0, '0);
        wr(3'd2, p2, 1'b0, '0);
    endtask

    task automatic set_all(input logic [2:0] c);
        for (int i = 0; i < PW; i++) bc[i] = c;
    endtask

    task automatic t_reset();
        check("R1", "match at reset", {31'd0, match}, 32'd0);
        check("R1", "hit at reset", {31'd0, hit}, 32'd0);
        smp(8'h00, "R1");
        check("R1", "zero word matches", {31'd0, match}, 32'd1);
        smp(8'h01, "R1");
        smp(8'h80, "R1");
    endtask

    task automatic t_level();
        set_all(3'd7); bc[0] = 3'd2; bc[1] = 3'd1; bc[5] = 3'd2;
        load_codes();
        wr(3'd5, 8'd3, 1'b0, '0);
        wr(3'd3, 8'h00, 1'b0, '0);
        smp(8'h21, "R2");
        check("R2", "levels met", {31'd0, match}, 32'd1);
        smp(8'h23, "R2");
        smp(8'h20, "R2");
        smp(8'hE5, "R2");
        smp(8'h01, "R2");
    endtask

    task automatic t_edge();
        wr(3'd5, 8'd3, 1'b0, '0);
        set_all(3'd7); bc[0] = 3'd3; load_codes();
        smp(8'h01, "R4");
        check("R4", "no rise on first sample", {31'd0, match}, 32'd0);
        smp(8'h00, "R3");
        smp(8'h01, "R3");
        check("R3", "rise seen", {31'd0, match}, 32'd1);
        smp(8'h01, "R3");
        smp(8'h00, "R3");
        idle(8'h01);
        smp(8'h01, "R3");
        check("R3", "idle kept history", {31'd0, match}, 32'd1);
        bc[0] = 3'd4; load_codes();
        smp(8'h00, "R4");
        smp(8'h01, "R3");
        smp(8'h00, "R3");
        bc[0] = 3'd5; load_codes();
        smp(8'h00, "R4");
        smp(8'h01, "R3");
        smp(8'h01, "R3");
        bc[0] = 3'd6; load_codes();
        smp(8'h01, "R4");
        check("R4", "no steady on first sample", {31'd0, match}, 32'd0);
        smp(8'h01, "R3");
        smp(8'h00, "R3");
    endtask

    task automatic t_cmp();
        set_all(3'd0); load_codes();
        wr(3'd3, 8'h40, 1'b0, '0);
        for (int f = 0; f < 6; f++) begin
            wr(3'd5, 8'(f), 1'b0, '0);
            smp(8'h3F, f < 2 ? "R5" : "R6");
            smp(8'h40, f < 2 ? "R5" : "R6");
            smp(8'h41, f < 2 ? "R5" : "R6");
            smp(8'hFF, f < 2 ? "R5" : "R6");
        end
        wr(3'd5, 8'd2, 1'b0, '0);
        smp(8'hC0, "R6");
        check("R6", "unsigned greater", {31'd0, match}, 32'd1);
        bc[7] = 3'd7; load_codes();
        wr(3'd5, 8'd0, 1'b0, '0);
        smp(8'hC0, "R5");
        check("R5", "masked bit ignored", {31'd0, match}, 32'd1);
        wr(3'd3, 8'hC1, 1'b0, '0);
        smp(8'h41, "R5");
        smp(8'h40, "R5");
    endtask

    task automatic t_range();
        set_all(3'd0); load_codes();
        wr(3'd3, 8'h10, 1'b0, '0);
        wr(3'd4, 8'h20, 1'b0, '0);
        wr(3'd5, 8'd6, 1'b0, '0);
        smp(8'h0F, "R7"); smp(8'h10, "R7");
        check("R7", "low bound inclusive", {31'd0, match}, 32'd1);
        smp(8'h20, "R7");
        check("R7", "high bound inclusive", {31'd0, match}, 32'd1);
        smp(8'h21, "R7"); smp(8'hF0, "R7");
        wr(3'd5, 8'd7, 1'b0, '0);
        smp(8'h0F, "R7"); smp(8'h10, "R7"); smp(8'h20, "R7"); smp(8'h21, "R7");
    endtask

    task automatic t_and();
        set_all(3'd0); bc[0] = 3'd2; load_codes();
        wr(3'd3, 8'h10, 1'b0, '0);
        wr(3'd5, 8'd4, 1'b0, '0);
        smp(8'h01, "R8");
        check("R8", "both hold", {31'd0, match}, 32'd1);
        smp(8'h02, "R8");
        smp(8'h11, "R8");
        check("R8", "word fails", {31'd0, match}, 32'd0);
    endtask

    task automatic t_count();
        set_all(3'd0); load_codes();
        wr(3'd3, 8'h00, 1'b0, '0);
        wr(3'd5, 8'd3, 1'b0, '0);
        wr(3'd6, 8'd3, 1'b0, '0);
        for (int k = 0; k < 6; k++) begin
            smp(8'(k), "R10");
            check("R12", "no counter follows match", {30'd0, hit2, match2}, {30'd0, match, match});
        end
        check("R10", "hit on sixth", {31'd0, hit}, 32'd1);
        wr(3'd6, 8'd0, 1'b0, '0);
        smp(8'h05, "R10");
        check("R10", "target zero fires", {31'd0, hit}, 32'd1);
        smp(8'h06, "R10");
        wr(3'd6, 8'd2, 1'b0, '0);
        wr(3'd5, 8'd0, 1'b0, '0);
        wr(3'd3, 8'h05, 1'b0, '0);
        smp(8'h05, "R10"); smp(8'h07, "R10"); smp(8'h05, "R10");
        check("R10", "non-match not counted", {31'd0, hit}, 32'd1);
        check("R12", "nocnt hit", {31'd0, hit2}, 32'd1);
    endtask

    task automatic t_wr_clear();
        set_all(3'd0); load_codes();
        wr(3'd5, 8'd3, 1'b0, '0);
        wr(3'd3, 8'h00, 1'b0, '0);
        wr(3'd6, 8'd3, 1'b0, '0);
        smp(8'h01, "R11"); smp(8'h02, "R11");
        wr(3'd3, 8'h00, 1'b0, '0);
        smp(8'h01, "R11"); smp(8'h02, "R11");
        check("R11", "count restarted", {31'd0, hit}, 32'd0);
        smp(8'h03, "R11");
        check("R11", "third after write hits", {31'd0, hit}, 32'd1);
        set_all(3'd7); bc[0] = 3'd3; load_codes();
        smp(8'h00, "R11");
        wr(3'd7, 8'h00, 1'b1, 8'h01);
        smp(8'h01, "R11");
        check("R11", "sample in write cycle not stored", {31'd0, match}, 32'd0);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        set_all(3'd0);
        b_lo = '0; b_hi = '0; b_prev = '0; b_func = '0;
        b_prev_ok = 1'b0; b_tgt = 0; b_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level();
        t_edge();
        t_cmp();
        t_range();
        t_and();
        t_count();
        t_wr_clear();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule